// File: doc/BRIEF.md
# Indexed Load/Store Address Generator

This block turns the address fields of a load or store into two numbers: the byte address the memory access uses, and the value the base register holds afterwards. It takes a 32-bit base, an offset, a direction bit that picks add or subtract, an index-timing bit and a writeback flag. The offset comes from one of three sources: a 12-bit unsigned immediate, a full register value, or a register value shifted left by a 5-bit constant.

Three addressing forms come out of the index-timing bit and the writeback flag:
- **Offset only.** The access goes to base ± offset and the base is left alone.
- **Pre-indexed.** The base moves to base ± offset and the access uses that moved value.
- **Post-indexed.** The access uses the untouched base, and the base then moves by the offset.

The result is registered. It appears one clock after the request, together with a valid strobe and a writeback enable. The register-file write port uses the writeback enable to decide whether to store the new base.

Top module: `ls_addr_gen`

## Requirements
- R1: While reset is held, `out_valid`, `wb_en`, `eff_addr` and `new_base` are all zero.
- R2: A request sampled with `req_valid`=1 on a rising edge produces `out_valid`=1 after that edge. A cycle with no request gives `out_valid`=0 after its edge.
- R3: Offset-only form (`pre_idx`=1, `wb_req`=0) gives `eff_addr` = base ± offset, `wb_en`=0 and `new_base` = base.
- R4: Pre-indexed form (`pre_idx`=1, `wb_req`=1) gives `wb_en`=1 and `eff_addr` = `new_base` = base ± offset. For example, base 0x200 with 4 subtracted gives 0x1FC for both outputs.
- R5: Post-indexed form (`pre_idx`=0) gives `eff_addr` = base, `new_base` = base ± offset and `wb_en`=1, whatever the value of `wb_req`. For example, base 0x200 with offset 12 gives address 0x200 and new base 0x20C. With 12 subtracted, the new base is 0x1F4.
- R6: `off_src` selects the offset source:
  - 2'b00: `imm_off` zero-extended.
  - 2'b01: `reg_off`.
  - 2'b10: `reg_off` shifted left by `shift_amt`.
  - 2'b11: an offset of zero.
- R7: `sub_en`=1 subtracts the offset from the base. `sub_en`=0 adds it.
- R8: All address arithmetic wraps modulo 2^32.
- R9: The shift amount ranges over 0 to 31, and bits shifted beyond bit 31 are lost. For example, 3 shifted by 2 gives 12, and 3 shifted by 31 gives 0x80000000.
- R10: In a cycle with no request, `wb_en` is 0 after the edge, and `eff_addr` and `new_base` keep their previous values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present this cycle |
| base_in | input | 32 | Base register value |
| off_src | input | 2 | Offset source select |
| imm_off | input | 12 | Unsigned immediate offset |
| reg_off | input | 32 | Register offset value |
| shift_amt | input | 5 | Left-shift amount for a shifted register offset |
| sub_en | input | 1 | 1 subtracts the offset, 0 adds it |
| pre_idx | input | 1 | 1 pre-indexed or offset only, 0 post-indexed |
| wb_req | input | 1 | Writeback flag for the pre-indexed forms |
| out_valid | output | 1 | Result valid |
| eff_addr | output | 32 | Effective access address |
| new_base | output | 32 | Base value after the access |
| wb_en | output | 1 | Base writeback enable |

## Verification
The only state in this block is the registered result, so any fault shows at the ports on the first edge after the request that provokes it.

Each kind of fault has a distinct signature:
- A wrong offset source or shift shows as a wrong sum on `eff_addr` or `new_base`.
- A mix-up between the pre- and post-indexed forms swaps which output carries the moved base.
- A stale writeback decision shows as `wb_en` set in an offset-only or idle cycle.

Idle cycles are checked as well, so a register that keeps loading without a request shows up one cycle later as a changed address.

// File: rtl/ls_addr_gen.sv
module ls_addr_gen #(
  parameter int AW    = 32,
  parameter int IMM_W = 12,
  parameter int SH_W  = 5
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            req_valid,
  input  logic [AW-1:0]   base_in,
  input  logic [1:0]      off_src,
  input  logic [IMM_W-1:0] imm_off,
  input  logic [AW-1:0]   reg_off,
  input  logic [SH_W-1:0] shift_amt,
  input  logic            sub_en,
  input  logic            pre_idx,
  input  logic            wb_req,
  output logic            out_valid,
  output logic [AW-1:0]   eff_addr,
  output logic [AW-1:0]   new_base,
  output logic            wb_en
);

  localparam logic [1:0] SRC_IMM   = 2'b00;
  localparam logic [1:0] SRC_REG   = 2'b01;
  localparam logic [1:0] SRC_SHIFT = 2'b10;
  localparam int         PAD_W     = AW - IMM_W;

  logic [AW-1:0] off_val;
  logic [AW-1:0] moved;
  logic          wb_next;

  always_comb begin
    case (off_src)
      SRC_IMM:   off_val = {{PAD_W{1'b0}}, imm_off};
      SRC_REG:   off_val = reg_off;
      SRC_SHIFT: off_val = reg_off << shift_amt;
      default:   off_val = '0;
    endcase
  end

  assign moved   = sub_en ? base_in - off_val : base_in + off_val;
  assign wb_next = !pre_idx || wb_req;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      wb_en     <= 1'b0;
      eff_addr  <= '0;
      new_base  <= '0;
    end else begin
      out_valid <= req_valid;
      wb_en     <= req_valid && wb_next;
      if (req_valid) begin
        eff_addr <= pre_idx ? moved : base_in;
        new_base <= wb_next ? moved : base_in;
      end
    end
  end

endmodule

// File: rtl/ls_addr_gen_chk.sv
module ls_addr_gen_chk #(
  parameter int AW    = 32,
  parameter int IMM_W = 12,
  parameter int SH_W  = 5
) (
  input logic             clk,
  input logic             rst_n,
  input logic             req_valid,
  input logic [AW-1:0]    base_in,
  input logic [1:0]       off_src,
  input logic [IMM_W-1:0] imm_off,
  input logic [AW-1:0]    reg_off,
  input logic [SH_W-1:0]  shift_amt,
  input logic             sub_en,
  input logic             pre_idx,
  input logic             wb_req,
  input logic             out_valid,
  input logic [AW-1:0]    eff_addr,
  input logic [AW-1:0]    new_base,
  input logic             wb_en
);

  // R2
  valid_follows_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> out_valid);

  // R2
  idle_no_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !out_valid);

  // R3
  offset_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && pre_idx && !wb_req) |=> (!wb_en && new_base == $past(base_in)));

  // R4
  pre_wb_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && pre_idx && wb_req) |=> (wb_en && eff_addr == new_base));

  // R5
  post_idx_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !pre_idx) |=> (wb_en && eff_addr == $past(base_in)));

  // R6
  zero_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && off_src == 2'b11) |=> (eff_addr == $past(base_in) && new_base == $past(base_in)));

  // R10
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> (!wb_en && $stable(eff_addr) && $stable(new_base)));

endmodule

bind ls_addr_gen ls_addr_gen_chk #(.AW(AW), .IMM_W(IMM_W), .SH_W(SH_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .base_in(base_in),
  .off_src(off_src), .imm_off(imm_off), .reg_off(reg_off), .shift_amt(shift_amt),
  .sub_en(sub_en), .pre_idx(pre_idx), .wb_req(wb_req), .out_valid(out_valid),
  .eff_addr(eff_addr), .new_base(new_base), .wb_en(wb_en)
);

// File: tb/test_ls_addr_gen.sv
module test_ls_addr_gen;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic [31:0] base_in = '0;
  logic [1:0]  off_src = '0;
  logic [11:0] imm_off = '0;
  logic [31:0] reg_off = '0;
  logic [4:0]  shift_amt = '0;
  logic        sub_en = 1'b0;
  logic        pre_idx = 1'b1;
  logic        wb_req = 1'b0;
  logic        out_valid;
  logic [31:0] eff_addr;
  logic [31:0] new_base;
  logic        wb_en;

  ls_addr_gen i_ls_addr_gen (.*);

  always #4 clk = ~clk;

  typedef struct {
    logic        v;
    logic [31:0] ea;
    logic [31:0] nb;
    logic        wb;
    string       tag;
  } item_t;

  item_t q[$];
  int checks = 0;
  int fails  = 0;
  logic [31:0] last_ea = '0;
  logic [31:0] last_nb = '0;

  task automatic check(string tag, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic drive(string tag, logic v, logic [31:0] b, logic [1:0] src,
                       logic [11:0] imm, logic [31:0] r, logic [4:0] sh,
                       logic sub, logic pre, logic wbf);
    item_t it;
    logic [31:0] off;
    logic [31:0] mv;
    logic        wbx;
    @(negedge clk);
    req_valid = v; base_in = b; off_src = src; imm_off = imm; reg_off = r;
    shift_amt = sh; sub_en = sub; pre_idx = pre; wb_req = wbf;
    case (src)
      2'b00: off = {20'b0, imm};
      2'b01: off = r;
      2'b10: off = r << sh;
      default: off = 32'h0;
    endcase
    mv  = sub ? b - off : b + off;
    wbx = !pre || wbf;
    it.v = v; it.tag = tag;
    if (v) begin
      it.ea = pre ? mv : b;
      it.nb = wbx ? mv : b;
      it.wb = wbx;
      last_ea = it.ea; last_nb = it.nb;
    end else begin
      it.ea = last_ea; it.nb = last_nb; it.wb = 1'b0;
    end
    q.push_back(it);
  endtask

  initial begin : monitor
    forever begin
      @(posedge clk);
      #2;
      if (q.size() > 0) begin
        item_t it;
        it = q.pop_front();
        check(it.v ? "R2" : "R2", "out_valid", {31'b0, out_valid}, {31'b0, it.v});
        check(it.tag, "eff_addr", eff_addr, it.ea);
        check(it.tag, "new_base", new_base, it.nb);
        check(it.tag, "wb_en", {31'b0, wb_en}, {31'b0, it.wb});
      end
    end
  end

  initial begin : watchdog
    #(8 * 200000);
    fails++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin : main
    logic [31:0] lf;
    repeat (3) @(posedge clk);
    #2;
    // R1 reset state
    check("R1", "out_valid", {31'b0, out_valid}, 32'h0);
    check("R1", "wb_en", {31'b0, wb_en}, 32'h0);
    check("R1", "eff_addr", eff_addr, 32'h0);
    check("R1", "new_base", new_base, 32'h0);
    @(negedge clk);
    rst_n = 1'b1;

    // R3 offset only, immediate add
    drive("R3", 1, 32'h0000_1000, 2'b00, 12'h024, 0, 0, 0, 1, 0);
    // R4 pre-index writeback, 0x200 - 4 = 0x1fc
    drive("R4", 1, 32'h200, 2'b00, 12'd4, 0, 0, 1, 1, 1);
    // R5 post-index 0x200 + 12
    drive("R5", 1, 32'h200, 2'b00, 12'd12, 0, 0, 0, 0, 1);
    // R5 post-index 0x200 - 12 = 0x1f4, writeback flag low still writes back
    drive("R5", 1, 32'h200, 2'b00, 12'd12, 0, 0, 1, 0, 0);
    // R10 idle cycles hold
    drive("R10", 0, 32'hDEAD_BEEF, 2'b01, 12'hFFF, 32'h55, 0, 0, 0, 1);
    drive("R10", 0, 32'h1234_5678, 2'b00, 12'h001, 0, 0, 1, 1, 1);
    // R6 register offset
    drive("R6", 1, 32'h4000, 2'b01, 12'hFFF, 32'h0000_0100, 5'd7, 0, 1, 0);
    // R9 shifted register 3 << 2 = 12
    drive("R9", 1, 32'h200, 2'b10, 0, 32'd3, 5'd2, 0, 0, 0);
    // R9 shift by 31
    drive("R9", 1, 32'h0, 2'b10, 0, 32'd3, 5'd31, 0, 1, 1);
    // R9 shift by 0
    drive("R9", 1, 32'h10, 2'b10, 0, 32'h20, 5'd0, 0, 1, 0);
    // R6 zero offset select
    drive("R6", 1, 32'hABCD_0000, 2'b11, 12'hFFF, 32'hFFFF_FFFF, 5'd4, 0, 0, 1);
    // R8 wrap on add and subtract
    drive("R8", 1, 32'hFFFF_FFF0, 2'b00, 12'h020, 0, 0, 0, 1, 1);
    drive("R8", 1, 32'h0000_0004, 2'b00, 12'h008, 0, 0, 1, 0, 0);
    // R7 subtract with register offset, largest immediate add
    drive("R7", 1, 32'h0001_0000, 2'b01, 0, 32'h0000_8000, 0, 1, 1, 1);
    drive("R7", 1, 32'h0001_0000, 2'b00, 12'hFFF, 0, 0, 0, 1, 0);
    drive("R10", 0, 32'h0, 2'b00, 0, 0, 0, 0, 0, 0);

    lf = 32'hACE1_2468;
    for (int i = 0; i < 300; i++) begin
      lf = {lf[30:0], lf[31] ^ lf[21] ^ lf[1] ^ lf[0]};
      drive(lf[3:2] == 2'b00 ? "R3" : (lf[4] ? "R5" : "R4"),
            lf[7:5] != 3'b000, lf ^ 32'h5A5A_0F0F, lf[9:8], lf[21:10],
            {lf[15:0], lf[31:16]}, lf[26:22], lf[27], lf[3:2] != 2'b11 ? 1'b1 : 1'b0,
            lf[28] | (lf[3:2] == 2'b01));
    end
    drive("R10", 0, 0, 0, 0, 0, 0, 0, 0, 0);
    repeat (3) @(posedge clk);
    #3;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule